// File: doc/BRIEF.md
# Low-Power Mode and Reset Sequencer

This block is the operating-mode controller of a system-support chip that powers and supervises a host microcontroller. It tracks five modes: Reset, Normal Request, Normal, Stop and Sleep. It drives an active-low reset to the host and an active-low interrupt. The host picks a mode by writing a 2-bit code, which arrives here as a one-cycle strobe. Reset is held for as long as any reset cause is present. After the cause clears, reset is held for a further fixed number of prescaled ticks.

Wake events are qualified by per-source glitch filters before they are acted on. Stop mode keeps the host supplied. It wakes on bus activity, wake inputs, cyclic sense, forced wake-up, chip-select activity, or the external reset pin held low. From Stop, the block goes straight to Normal or to Normal Request, depending on the watchdog strap, and it pulls the interrupt low. Sleep mode has the host unpowered. It wakes only on the generic wake sources and restarts through Reset.

If the host sends no mode code while the block is in Normal Request, the block times out back to Reset.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset the mode is Reset (code 000), `rst_n_o` is low and `irq_n_o` is high.
- R2: While `rst_cause_i` is high, in any mode, the block enters Reset on the next clock edge and keeps `rst_n_o` low.
- R3: After `rst_cause_i` was last sampled high, `rst_n_o` rises exactly EXT_TICKS*PRESC_DIV clock edges later. The mode is then Normal Request (code 001).
- R4: In Normal Request or Normal, an accepted strobe (`cmd_valid_i`=1) sets the mode from `cmd_i`: 00 gives Normal (010), 01 gives Stop (011), 10 gives Sleep (100). Code 11 (watchdog clear) leaves the mode unchanged. `cmd_i` is ignored while `cmd_valid_i` is low.
- R5: In Normal Request, with no accepted code 00, 01 or 10, the block returns to Reset NRQ_TICKS*PRESC_DIV clock edges after it entered Normal Request.
- R6: Mode strobes have no effect in Stop or Sleep.
- R7: A wake source counts only after FILT_N consecutive asserted samples. The mode changes on the edge after the FILT_N-th sample. A pulse of FILT_N-1 cycles causes no wake.
- R8: In Stop, any `wake_i` bit, `cs_act_i` high, or `ext_rst_n_i` low wakes the block. It goes to Normal Request if `wd_strap_i`=1 and to Normal if `wd_strap_i`=0.
- R9: A wake from Stop pulls `irq_n_o` low on the same edge as the mode change. `irq_n_o` stays low until the next accepted strobe of any code.
- R10: In Sleep, only `wake_i` wakes the block, and it goes to Reset, then runs the R3 extension. `cs_act_i` and `ext_rst_n_i` are ignored in Sleep, and `irq_n_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rst_cause_i | input | 1 | A reset cause is present (supply fault, watchdog failure) |
| wd_strap_i | input | 1 | Watchdog strap; 1 means a Stop wake goes to Normal Request |
| cmd_valid_i | input | 1 | One-cycle strobe of a mode write |
| cmd_i | input | 2 | Mode code |
| wake_i | input | NWAKE | Generic wake sources (bus, wake inputs, cyclic sense, forced) |
| cs_act_i | input | 1 | Chip select asserted |
| ext_rst_n_i | input | 1 | Sensed level of the external reset pin |
| mode_o | output | 3 | Current mode code |
| rst_n_o | output | 1 | Active-low reset to the host |
| irq_n_o | output | 1 | Active-low wake interrupt |

## Verification
The bench measures the reset extension and the Normal Request timeout to the exact clock edge. A design off by one tick or one prescaler cycle would release reset, or time out, one edge early or late.

Wake pulses are driven at one cycle shorter than the filter length and at exactly the filter length. A filter that counts one too few or one too many samples would wake on the glitch, or miss the valid pulse.

The bench also sends mode codes while in Stop and Sleep, and drives chip select and the reset pin during Sleep. A design that obeyed any of these would leave a low-power mode it should hold.

The strap is tested in both settings, to catch a Stop wake sent to the wrong mode. The interrupt is checked after both kinds of wake, to catch a Sleep wake that pulls it low or a Stop wake that never releases it.

// File: rtl/lpm_seq_pkg.sv
package lpm_seq_pkg;
  typedef enum logic [2:0] {
    M_RESET  = 3'd0,
    M_NREQ   = 3'd1,
    M_NORMAL = 3'd2,
    M_STOP   = 3'd3,
    M_SLEEP  = 3'd4
  } mode_e;

  localparam logic [1:0] CMD_NORMAL = 2'b00;
  localparam logic [1:0] CMD_STOP   = 2'b01;
  localparam logic [1:0] CMD_SLEEP  = 2'b10;
  localparam logic [1:0] CMD_WDCLR  = 2'b11;
endpackage

// File: rtl/lpm_wake_filter.sv
module lpm_wake_filter #(
  parameter int FILT_N = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic raw_i,
  output logic hit_o
);
  localparam int CW = $clog2(FILT_N + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_N);

  logic [CW-1:0] cnt_q, cnt_d;

  // consecutive-sample counter, saturating at FILT_N
  always_comb begin
    if (!raw_i)             cnt_d = '0;
    else if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign hit_o = (cnt_q == FULL);
endmodule

// File: rtl/lpm_tick_timer.sv
module lpm_tick_timer #(
  parameter int PRESC_DIV = 1000,
  parameter int TW        = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          clr_i,
  output logic          tick_o,
  output logic [TW-1:0] tk_o
);
  localparam int PW = $clog2(PRESC_DIV + 1);
  localparam logic [PW-1:0] PLAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [TW-1:0] tk_q, tk_d;

  assign tick_o = (pre_q == PLAST);

  always_comb begin
    pre_d = pre_q;
    tk_d  = tk_q;
    if (clr_i) begin
      pre_d = '0;
      tk_d  = '0;
    end else if (tick_o) begin
      pre_d = '0;
      if (tk_q != {TW{1'b1}}) tk_d = tk_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pre_q <= '0;
      tk_q  <= '0;
    end else begin
      pre_q <= pre_d;
      tk_q  <= tk_d;
    end
  end

  assign tk_o = tk_q;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_seq_pkg::*;
#(
  parameter int TW        = 8,
  parameter int EXT_TICKS = 20,
  parameter int NRQ_TICKS = 150
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          cause_i,
  input  logic          strap_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_i,
  input  logic          wake_stop_i,
  input  logic          wake_sleep_i,
  input  logic          tick_i,
  input  logic [TW-1:0] tk_i,
  output mode_e         mode_o,
  output logic          clr_o,
  output logic          irq_n_o
);
  localparam logic [TW-1:0] EXT_LAST = TW'(EXT_TICKS - 1);
  localparam logic [TW-1:0] NRQ_LAST = TW'(NRQ_TICKS - 1);

  mode_e state_q, state_d;
  logic  irq_q, irq_d;
  logic  cmd_move, stop_wake;
  mode_e cmd_target;

  always_comb begin
    unique case (cmd_i)
      CMD_STOP:  cmd_target = M_STOP;
      CMD_SLEEP: cmd_target = M_SLEEP;
      default:   cmd_target = M_NORMAL;
    endcase
  end

  assign cmd_move  = cmd_valid_i && (cmd_i != CMD_WDCLR);
  assign stop_wake = (state_q == M_STOP) && !cause_i && wake_stop_i;

  // next-state
  always_comb begin
    state_d = state_q;
    if (cause_i) begin
      state_d = M_RESET;
    end else begin
      unique case (state_q)
        M_RESET:  if (tick_i && tk_i == EXT_LAST) state_d = M_NREQ;
        M_NREQ: begin
          if (cmd_move)                           state_d = cmd_target;
          else if (tick_i && tk_i == NRQ_LAST)    state_d = M_RESET;
        end
        M_NORMAL: if (cmd_move)                   state_d = cmd_target;
        M_STOP:   if (wake_stop_i)                state_d = strap_i ? M_NREQ : M_NORMAL;
        M_SLEEP:  if (wake_sleep_i)               state_d = M_RESET;
        default:                                  state_d = M_RESET;
      endcase
    end
  end

  assign clr_o = (state_d != state_q) || (state_q == M_RESET && cause_i);

  always_comb begin
    irq_d = irq_q;
    if (cmd_valid_i) irq_d = 1'b1;
    if (stop_wake)   irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= M_RESET;
      irq_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  assign mode_o  = state_q;
  assign irq_n_o = irq_q;
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_seq_pkg::*;
#(
  parameter int NWAKE     = 4,
  parameter int PRESC_DIV = 1000,
  parameter int EXT_TICKS = 20,
  parameter int NRQ_TICKS = 150,
  parameter int FILT_N    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_cause_i,
  input  logic             wd_strap_i,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_i,
  input  logic [NWAKE-1:0] wake_i,
  input  logic             cs_act_i,
  input  logic             ext_rst_n_i,
  output logic [2:0]       mode_o,
  output logic             rst_n_o,
  output logic             irq_n_o
);
  localparam int TMAX = (EXT_TICKS > NRQ_TICKS) ? EXT_TICKS : NRQ_TICKS;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int NSRC = NWAKE + 2;

  logic [1:0]      rs_q;
  logic            arst_n;
  logic [NSRC-1:0] raw, hit;
  logic            tick, clr;
  logic [TW-1:0]   tk;
  mode_e           mode;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  // generic sources low, chip select and reset pin on top
  assign raw = {~ext_rst_n_i, cs_act_i, wake_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_filt
    lpm_wake_filter #(.FILT_N(FILT_N)) u_filt (
      .clk(clk), .arst_n(arst_n), .raw_i(raw[g]), .hit_o(hit[g])
    );
  end

  lpm_tick_timer #(.PRESC_DIV(PRESC_DIV), .TW(TW)) u_timer (
    .clk(clk), .arst_n(arst_n), .clr_i(clr), .tick_o(tick), .tk_o(tk)
  );

  lpm_mode_fsm #(.TW(TW), .EXT_TICKS(EXT_TICKS), .NRQ_TICKS(NRQ_TICKS)) u_fsm (
    .clk(clk), .arst_n(arst_n),
    .cause_i(rst_cause_i), .strap_i(wd_strap_i),
    .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .wake_stop_i(|hit), .wake_sleep_i(|hit[NWAKE-1:0]),
    .tick_i(tick), .tk_i(tk),
    .mode_o(mode), .clr_o(clr), .irq_n_o(irq_n_o)
  );

  assign mode_o  = mode;
  assign rst_n_o = (mode != M_RESET);
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_cause_i,
  input logic       wd_strap_i,
  input logic [2:0] mode_o,
  input logic       rst_n_o,
  input logic       irq_n_o
);
  // R2
  a_r2_cause_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cause_i |=> (mode_o == 3'd0 && !rst_n_o));

  // R3
  a_r3_release_to_nreq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_o) |-> (mode_o == 3'd1));

  // R8
  a_r8_strap_blocks_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3 && !rst_cause_i && wd_strap_i) |=> (mode_o != 3'd2));

  // R9
  a_r9_irq_only_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> ($past(mode_o) == 3'd3));

  // R10
  a_r10_sleep_exit_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && !rst_cause_i) |=> (mode_o == 3'd4 || mode_o == 3'd0));
endmodule

bind lpm_sequencer lpm_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_cause_i(rst_cause_i), .wd_strap_i(wd_strap_i),
  .mode_o(mode_o), .rst_n_o(rst_n_o), .irq_n_o(irq_n_o)
);

// File: tb/tb_lpm_sequencer.sv
module tb_lpm_sequencer;
  localparam int PRESC = 4;
  localparam int EXT   = 3;
  localparam int NRQ   = 5;
  localparam int FILT  = 3;

  logic       clk = 1'b0;
  logic       rst_n, cause, strap, valid, cs, pin;
  logic [1:0] cmd;
  logic [3:0] wake;
  logic [2:0] mode;
  logic       rst_out, irq;
  int         checks = 0;
  int         errs   = 0;
  bit         done   = 0;

  always #10 clk = ~clk;

  lpm_sequencer #(.NWAKE(4), .PRESC_DIV(PRESC), .EXT_TICKS(EXT),
                  .NRQ_TICKS(NRQ), .FILT_N(FILT)) dut (
    .clk(clk), .rst_n(rst_n), .rst_cause_i(cause), .wd_strap_i(strap),
    .cmd_valid_i(valid), .cmd_i(cmd), .wake_i(wake), .cs_act_i(cs),
    .ext_rst_n_i(pin), .mode_o(mode), .rst_n_o(rst_out), .irq_n_o(irq)
  );

  // {cause, valid, cmd[1:0], expected mode[2:0]}, walked from Normal
  localparam logic [6:0] VEC [7] = '{
    {1'b0, 1'b1, 2'b11, 3'd2},   // R4 clear only
    {1'b0, 1'b1, 2'b00, 3'd2},   // R4 normal stays
    {1'b0, 1'b0, 2'b01, 3'd2},   // R4 no strobe
    {1'b0, 1'b1, 2'b01, 3'd3},   // R4 to stop
    {1'b0, 1'b1, 2'b00, 3'd3},   // R6 ignored in stop
    {1'b0, 1'b1, 2'b10, 3'd3},   // R6 ignored in stop
    {1'b1, 1'b0, 2'b00, 3'd0}    // R2 cause in stop
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] c);
    valid = 1'b1; cmd = c;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic count_until_rst_high(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!rst_out && n < 500);
  endtask

  task automatic go_nreq();
    for (int k = 0; k < 500 && mode != 3'd1; k++) @(negedge clk);
  endtask

  task automatic pulse(input int which, input int n);
    case (which)
      0: wake[0] = 1'b1;
      2: wake[2] = 1'b1;
      4: cs = 1'b1;
      default: pin = 1'b0;
    endcase
    repeat (n) @(negedge clk);
    wake = '0; cs = 1'b0; pin = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; cause = 1'b1; strap = 1'b1; valid = 1'b0; cmd = 2'b00;
    wake = '0; cs = 1'b0; pin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 mode", mode, 0);
    chk("R1 rst_n_o", rst_out, 0);
    chk("R1 irq_n_o", irq, 1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 held by cause", rst_out, 0);

    cause = 1'b0;
    count_until_rst_high(n);
    chk("R3 extension length", n, EXT * PRESC);
    chk("R3 exit mode", mode, 1);

    n = 0;
    do begin @(negedge clk); n++; end while (mode != 3'd0 && n < 500);
    chk("R5 timeout length", n, NRQ * PRESC);
    go_nreq();

    send(2'b11);
    chk("R4 clear in nreq", mode, 1);
    send(2'b00);
    chk("R4 nreq to normal", mode, 2);

    for (int i = 0; i < 7; i++) begin
      cause = VEC[i][6]; valid = VEC[i][5]; cmd = VEC[i][4:3];
      @(negedge clk);
      chk($sformatf("R4/R6/R2 vector %0d", i), mode, int'(VEC[i][2:0]));
      cause = 1'b0; valid = 1'b0;
    end

    go_nreq();
    send(2'b01);
    chk("R4 nreq to stop", mode, 3);
    pulse(0, FILT - 1);
    chk("R7 short pulse ignored", mode, 3);
    chk("R7 irq idle", irq, 1);
    pulse(0, FILT);
    chk("R8 strap1 to nreq", mode, 1);
    chk("R9 irq low", irq, 0);
    send(2'b00);
    chk("R9 irq cleared", irq, 1);
    chk("R4 normal", mode, 2);

    strap = 1'b0;
    send(2'b01);
    pulse(5, FILT);
    chk("R8 pin wake strap0", mode, 2);
    chk("R9 irq low pin wake", irq, 0);
    send(2'b11);
    chk("R9 irq cleared by clear code", irq, 1);
    chk("R4 clear keeps normal", mode, 2);

    send(2'b01);
    send(2'b00);
    chk("R6 stop ignores cmd", mode, 3);
    pulse(4, FILT);
    chk("R8 cs wake", mode, 2);
    send(2'b11);

    send(2'b10);
    chk("R4 to sleep", mode, 4);
    pulse(4, FILT + 1);
    chk("R10 cs ignored", mode, 4);
    pulse(5, FILT + 1);
    chk("R10 pin ignored", mode, 4);
    send(2'b00);
    chk("R6 sleep ignores cmd", mode, 4);
    pulse(2, FILT);
    chk("R10 sleep wake to reset", mode, 0);
    chk("R10 irq stays high", irq, 1);
    count_until_rst_high(n);
    chk("R10 extension after sleep", n, EXT * PRESC);
    chk("R10 then nreq", mode, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule